// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block turns a single-cycle exception strobe into the processor state changes that a trap requires. It receives the class of the event (general trap, error-class entry for reset or non-maskable interrupt, or debug entry), a 5-bit trap code, the address of the trapping instruction, a delay-slot flag, and the faulting virtual address. On the next clock edge it updates its privileged state registers and issues a one-cycle redirect carrying the new fetch address.

The return address for each class is stored in that class's own register. When the trapping instruction sat in a branch delay slot, the stored value points back at the branch. A general trap that arrives while the trap-level flag is already set leaves the saved return address and the delay-slot indicator alone. Translation faults also record the faulting address in three forms: a raw copy, a page-table index and a translation tag. The general vector comes either from a fixed boot address or from a programmable base, plus an offset chosen by the kind of trap.

A simple write port and a combinational read port give access to the registers. A write in the same cycle as a strobe is discarded.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the status register reads 0x00400000 (only the boot-vector bit 22 set), the cause register reads 0, the vector base reads 0x80000000 and `redirect` is low.
- R2: A general trap (class 0) taken with the trap-level bit (status bit 1) clear stores PC-4 into the return-address register and sets cause bit 31 when `exc_dslot` is high. Otherwise it stores PC and clears cause bit 31.
- R3: A general trap taken with status bit 1 already set leaves the return-address register and cause bit 31 unchanged.
- R4: Every general trap sets status bit 1 and writes `exc_code` into cause bits 6:2.
- R5: The general vector base is 0xBFC00200 when status bit 22 is set. Otherwise it is the programmable base register, whose bits 9:0 always read 0.
- R6: The general vector offset is 0x000 for a refill trap taken with status bit 1 clear. It is 0x200 for an interrupt (code 0) when cause bit 23 is set. In every other case it is 0x180.
- R7: An error-class entry (class 1) stores the delay-slot-adjusted PC in the error return register, sets status bits 2 and 22, jumps to 0xBFC00000, and leaves the general return-address register unchanged.
- R8: A debug entry (class 2) stores the delay-slot-adjusted PC in the debug return register, jumps to 0xBFC00480, and leaves status bit 1 unchanged.
- R9: A general trap with `exc_addr_fault` high loads the bad-address register with the faulting address. It loads context bits 22:4 with address bits 31:13 and keeps context bits 31:23. It sets the translation tag to address bits 31:13 at bits 31:13, with the current 8-bit identifier kept in bits 7:0.
- R10: A trap with `exc_addr_fault` low leaves the bad-address, context and tag registers unchanged.
- R11: Any entry clears the two mode bits (status bits 4:3), which forces kernel mode.
- R12: State updates and the new PC take effect on the clock edge that samples the strobe. `redirect` is high for exactly the following cycle.
- R13: Register selectors are: 0 status, 1 cause, 2 return address, 3 bad address, 4 context, 5 tag, 6 error return, 7 debug return, 8 vector base. A host write in the same cycle as a strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Single-cycle trap strobe |
| exc_class | input | 2 | 0 general, 1 error class, 2 debug |
| exc_code | input | 5 | Trap code written to the cause register |
| exc_refill | input | 1 | Trap is a translation refill miss |
| exc_addr_fault | input | 1 | Trap records the faulting address |
| exc_pc | input | 32 | Address of the trapping instruction |
| exc_dslot | input | 1 | Trapping instruction was in a delay slot |
| exc_badva | input | 32 | Faulting virtual address |
| wr_en | input | 1 | Host register write enable |
| wr_sel | input | 4 | Host write register selector |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 4 | Read register selector |
| rd_data | output | 32 | Selected register contents |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| new_pc | output | 32 | Fetch target during the redirect |

## Verification
General traps are driven with the trap-level bit both clear and set, and both in and out of a delay slot. This separates the save path from the hold path and exposes a missing minus-four adjustment. Refill, interrupt and ordinary codes are crossed with the boot-vector bit and the interrupt-vector bit, so each base and each offset is selected at least once. Fault and non-fault traps are interleaved to confirm that the address-capture registers move only on faults. Error-class and debug entries check that they write only their own return registers.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      CLS_GENERAL = 2'd0,
      CLS_ERROR   = 2'd1,
      CLS_DEBUG   = 2'd2
   } exc_class_e;

   typedef enum logic [3:0] {
      SEL_STATUS  = 4'd0,
      SEL_CAUSE   = 4'd1,
      SEL_EPC     = 4'd2,
      SEL_BADVA   = 4'd3,
      SEL_CONTEXT = 4'd4,
      SEL_TAG     = 4'd5,
      SEL_ERRPC   = 4'd6,
      SEL_DBGPC   = 4'd7,
      SEL_VBASE   = 4'd8
   } reg_sel_e;

   // status bit positions
   localparam int ST_EXL    = 1;
   localparam int ST_ERL    = 2;
   localparam int ST_KSU_LO = 3;
   localparam int ST_BEV    = 22;
   // cause bit positions
   localparam int CA_CODE_LO = 2;
   localparam int CA_IV      = 23;
   localparam int CA_BD      = 31;

   localparam logic [31:0] VEC_BOOT_GENERAL = 32'hBFC0_0200;
   localparam logic [31:0] VEC_ERROR        = 32'hBFC0_0000;
   localparam logic [31:0] VEC_DEBUG        = 32'hBFC0_0480;
   localparam logic [31:0] OFS_REFILL       = 32'h0000_0000;
   localparam logic [31:0] OFS_INTR         = 32'h0000_0200;
   localparam logic [31:0] OFS_COMMON       = 32'h0000_0180;
   localparam logic [31:0] VBASE_RESET      = 32'h8000_0000;

endpackage

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0] pc,
   input  logic            dslot,
   output logic [XLEN-1:0] ret
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   // a fault in a delay slot resumes at the branch before it
   assign ret = dslot ? (pc - STEP) : pc;
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
   parameter int XLEN      = 32,
   parameter int VBASE_LSB = 10,
   parameter bit USE_IV    = 1'b1
) (
   input  logic            bev,
   input  logic [XLEN-1:0] vbase,
   input  logic            exl,
   input  logic            refill,
   input  logic            intr,
   input  logic            iv,
   output logic [XLEN-1:0] vec
);
   import exc_pkg::*;

   localparam logic [XLEN-1:0] BASE_MASK = ~((XLEN'(1) << VBASE_LSB) - XLEN'(1));

   logic            iv_hit;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] ofs;

   generate
      if (USE_IV) begin : g_iv
         assign iv_hit = intr & iv;
      end else begin : g_no_iv
         assign iv_hit = 1'b0 & intr & iv;
      end
   endgenerate

   always_comb begin
      base = bev ? VEC_BOOT_GENERAL : (vbase & BASE_MASK);
      if (refill && !exl)
         ofs = OFS_REFILL;
      else if (iv_hit)
         ofs = OFS_INTR;
      else
         ofs = OFS_COMMON;
      vec = base + ofs;
   end
endmodule

// File: rtl/exc_fault_capture.sv
module exc_fault_capture #(
   parameter int XLEN       = 32,
   parameter int ASID_W     = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int CTX_LSB    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [XLEN-1:0] fault_va,
   input  logic            ctx_wr,
   input  logic            tag_wr,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] badva,
   output logic [XLEN-1:0] context_o,
   output logic [XLEN-1:0] tag_o
);
   localparam int VPN2_LSB = PAGE_SHIFT + 1;
   localparam int VPN2_W   = XLEN - VPN2_LSB;
   localparam int CTX_TOP  = CTX_LSB + VPN2_W;
   localparam logic [XLEN-1:0] ONE       = XLEN'(1);
   localparam logic [XLEN-1:0] CTX_BASE  = ~((ONE << CTX_TOP) - ONE);
   localparam logic [XLEN-1:0] ASID_MASK = (ONE << ASID_W) - ONE;
   localparam logic [XLEN-1:0] VPN2_MASK = ~((ONE << VPN2_LSB) - ONE);

   generate
      if (CTX_TOP > XLEN) begin : g_bad_ctx
         $error("context index field does not fit the register");
      end
      if (ASID_W > VPN2_LSB) begin : g_bad_asid
         $error("identifier overlaps the page-pair tag");
      end
   endgenerate

   logic [XLEN-1:0] badva_q, ctx_q, tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         badva_q <= '0;
         ctx_q   <= '0;
         tag_q   <= '0;
      end else if (capture) begin
         badva_q <= fault_va;
         ctx_q   <= (ctx_q & CTX_BASE) | ((fault_va >> VPN2_LSB) << CTX_LSB);
         tag_q   <= (fault_va & VPN2_MASK) | (tag_q & ASID_MASK);
      end else begin
         if (ctx_wr)
            ctx_q <= (wr_data & CTX_BASE) | (ctx_q & ~CTX_BASE);
         if (tag_wr)
            tag_q <= wr_data & (VPN2_MASK | ASID_MASK);
      end
   end

   assign badva     = badva_q;
   assign context_o = ctx_q;
   assign tag_o     = tag_q;
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
   parameter int XLEN       = 32,
   parameter int CODE_W     = 5,
   parameter int ASID_W     = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int CTX_LSB    = 4,
   parameter int VBASE_LSB  = 10,
   parameter int INSN_BYTES = 4,
   parameter bit USE_IV     = 1'b1,
   parameter bit HAS_DEBUG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [1:0]        exc_class,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              exc_refill,
   input  logic              exc_addr_fault,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic              exc_dslot,
   input  logic [XLEN-1:0]   exc_badva,
   input  logic              wr_en,
   input  logic [3:0]        wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [3:0]        rd_sel,
   output logic [XLEN-1:0]   rd_data,
   output logic              redirect,
   output logic [XLEN-1:0]   new_pc
);
   import exc_pkg::*;

   localparam logic [XLEN-1:0] VBASE_MASK = ~((XLEN'(1) << VBASE_LSB) - XLEN'(1));

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("fixed vectors assume a 32-bit address");
      end
      if (CA_CODE_LO + CODE_W > CA_IV) begin : g_bad_code
         $error("trap code field overlaps the interrupt-vector bit");
      end
   endgenerate

   // state
   logic              exl_q, erl_q, bev_q, iv_q, bd_q;
   logic [1:0]        ksu_q;
   logic [CODE_W-1:0] code_q;
   logic [XLEN-1:0]   epc_q, errpc_q, dbgpc_q, vbase_q;
   logic              redirect_q;
   logic [XLEN-1:0]   new_pc_q;

   logic [XLEN-1:0]   ret_addr, gen_vec, target;
   logic [XLEN-1:0]   badva_w, context_w, tag_w;
   logic              is_gen, is_err, is_dbg, host_wr;

   assign is_gen  = exc_valid && (exc_class == CLS_GENERAL);
   assign is_err  = exc_valid && (exc_class == CLS_ERROR);
   assign is_dbg  = exc_valid && (exc_class == CLS_DEBUG);
   assign host_wr = wr_en && !exc_valid;

   exc_ret_addr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
      .pc    (exc_pc),
      .dslot (exc_dslot),
      .ret   (ret_addr)
   );

   exc_vector_sel #(.XLEN(XLEN), .VBASE_LSB(VBASE_LSB), .USE_IV(USE_IV)) u_vec (
      .bev    (bev_q),
      .vbase  (vbase_q),
      .exl    (exl_q),
      .refill (exc_refill),
      .intr   (exc_code == '0),
      .iv     (iv_q),
      .vec    (gen_vec)
   );

   exc_fault_capture #(
      .XLEN(XLEN), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT), .CTX_LSB(CTX_LSB)
   ) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (is_gen && exc_addr_fault),
      .fault_va  (exc_badva),
      .ctx_wr    (host_wr && (wr_sel == SEL_CONTEXT)),
      .tag_wr    (host_wr && (wr_sel == SEL_TAG)),
      .wr_data   (wr_data),
      .badva     (badva_w),
      .context_o (context_w),
      .tag_o     (tag_w)
   );

   // status
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exl_q <= 1'b0;
         erl_q <= 1'b0;
         bev_q <= 1'b1;
         ksu_q <= 2'b00;
      end else if (exc_valid) begin
         ksu_q <= 2'b00;
         if (is_gen)
            exl_q <= 1'b1;
         if (is_err) begin
            erl_q <= 1'b1;
            bev_q <= 1'b1;
         end
      end else if (host_wr && (wr_sel == SEL_STATUS)) begin
         exl_q <= wr_data[ST_EXL];
         erl_q <= wr_data[ST_ERL];
         bev_q <= wr_data[ST_BEV];
         ksu_q <= wr_data[ST_KSU_LO +: 2];
      end
   end

   // cause and general return address
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         bd_q   <= 1'b0;
         iv_q   <= 1'b0;
         epc_q  <= '0;
      end else if (is_gen) begin
         code_q <= exc_code;
         if (!exl_q) begin
            bd_q  <= exc_dslot;
            epc_q <= ret_addr;
         end
      end else if (host_wr) begin
         if (wr_sel == SEL_CAUSE)
            iv_q <= wr_data[CA_IV];
         if (wr_sel == SEL_EPC)
            epc_q <= wr_data;
      end
   end

   // error-class return address and vector base
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         errpc_q <= '0;
         vbase_q <= VBASE_RESET;
      end else begin
         if (is_err)
            errpc_q <= ret_addr;
         if (host_wr && (wr_sel == SEL_VBASE))
            vbase_q <= wr_data & VBASE_MASK;
      end
   end

   generate
      if (HAS_DEBUG) begin : g_dbg
         always_ff @(posedge clk) begin
            if (!rst_n)
               dbgpc_q <= '0;
            else if (is_dbg)
               dbgpc_q <= ret_addr;
         end
      end else begin : g_no_dbg
         assign dbgpc_q = '0;
      end
   endgenerate

   // redirect
   always_comb begin
      unique case (exc_class_e'(exc_class))
         CLS_ERROR: target = VEC_ERROR;
         CLS_DEBUG: target = VEC_DEBUG;
         default:   target = gen_vec;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_q <= 1'b0;
         new_pc_q   <= '0;
      end else begin
         redirect_q <= exc_valid;
         if (exc_valid)
            new_pc_q <= target;
      end
   end

   assign redirect = redirect_q;
   assign new_pc   = new_pc_q;

   // read port
   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_sel))
         SEL_STATUS: begin
            rd_data[ST_EXL]         = exl_q;
            rd_data[ST_ERL]         = erl_q;
            rd_data[ST_KSU_LO +: 2] = ksu_q;
            rd_data[ST_BEV]         = bev_q;
         end
         SEL_CAUSE: begin
            rd_data[CA_CODE_LO +: CODE_W] = code_q;
            rd_data[CA_IV]                = iv_q;
            rd_data[CA_BD]                = bd_q;
         end
         SEL_EPC:     rd_data = epc_q;
         SEL_BADVA:   rd_data = badva_w;
         SEL_CONTEXT: rd_data = context_w;
         SEL_TAG:     rd_data = tag_w;
         SEL_ERRPC:   rd_data = errpc_q;
         SEL_DBGPC:   rd_data = dbgpc_q;
         SEL_VBASE:   rd_data = vbase_q;
         default:     rd_data = '0;
      endcase
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_valid,
   input logic [1:0]      exc_class,
   input logic            exc_dslot,
   input logic [XLEN-1:0] exc_pc,
   input logic            exc_addr_fault,
   input logic [XLEN-1:0] exc_badva,
   input logic            redirect,
   input logic [XLEN-1:0] new_pc,
   input logic            exl_q,
   input logic [1:0]      ksu_q,
   input logic [XLEN-1:0] epc_q,
   input logic [XLEN-1:0] badva_w
);
   AST_EPC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd0 && !exl_q) |=>
      epc_q == ($past(exc_dslot) ? $past(exc_pc) - 32'd4 : $past(exc_pc))); // R2
   AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd0 && exl_q) |=> $stable(epc_q)); // R3
   AST_EXL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd0) |=> exl_q); // R4
   AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd1) |=> (new_pc == 32'hBFC0_0000 && $stable(epc_q))); // R7
   AST_DBG_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd2) |=> new_pc == 32'hBFC0_0480); // R8
   AST_BADVA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd0 && exc_addr_fault) |=> badva_w == $past(exc_badva)); // R9
   AST_BADVA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !exc_addr_fault) |=> $stable(badva_w)); // R10
   AST_KERNEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> ksu_q == 2'b00); // R11
   AST_REDIRECT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> redirect); // R12
   AST_REDIRECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |=> !redirect); // R12
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .exc_valid      (exc_valid),
   .exc_class      (exc_class),
   .exc_dslot      (exc_dslot),
   .exc_pc         (exc_pc),
   .exc_addr_fault (exc_addr_fault),
   .exc_badva      (exc_badva),
   .redirect       (redirect),
   .new_pc         (new_pc),
   .exl_q          (exl_q),
   .ksu_q          (ksu_q),
   .epc_q          (epc_q),
   .badva_w        (badva_w)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] S_STATUS = 4'd0, S_CAUSE = 4'd1, S_EPC = 4'd2, S_BADVA = 4'd3,
                          S_CTX = 4'd4, S_TAG = 4'd5, S_ERRPC = 4'd6, S_DBGPC = 4'd7,
                          S_VBASE = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [1:0]  exc_class = 2'd0;
   logic [4:0]  exc_code = 5'd0;
   logic        exc_refill = 1'b0;
   logic        exc_addr_fault = 1'b0;
   logic [31:0] exc_pc = '0;
   logic        exc_dslot = 1'b0;
   logic [31:0] exc_badva = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        redirect;
   logic [31:0] new_pc;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_unit u_dut (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_class(exc_class),
      .exc_code(exc_code), .exc_refill(exc_refill), .exc_addr_fault(exc_addr_fault),
      .exc_pc(exc_pc), .exc_dslot(exc_dslot), .exc_badva(exc_badva),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .redirect(redirect), .new_pc(new_pc)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic rd(input logic [3:0] sel, output logic [31:0] v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic wr(input logic [3:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // strobe one trap; returns at the negedge where the redirect is visible
   task automatic fire(input logic [1:0] cls, input logic [4:0] code, input logic refill,
                       input logic fault, input logic [31:0] pc, input logic dslot,
                       input logic [31:0] va, output logic redir, output logic [31:0] tpc);
      @(negedge clk);
      exc_class = cls; exc_code = code; exc_refill = refill; exc_addr_fault = fault;
      exc_pc = pc; exc_dslot = dslot; exc_badva = va; exc_valid = 1'b1;
      @(negedge clk);
      exc_valid = 1'b0; exc_refill = 1'b0; exc_addr_fault = 1'b0;
      redir = redirect;
      tpc = new_pc;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(S_STATUS, v); chk("R1", "status after reset", v, 32'h0040_0000);
      rd(S_CAUSE, v);  chk("R1", "cause after reset", v, 32'h0);
      rd(S_VBASE, v);  chk("R1", "vector base after reset", v, 32'h8000_0000);
      chk("R1", "redirect after reset", {31'b0, redirect}, 32'h0);
   endtask

   task automatic t_setup;
      logic [31:0] v;
      wr(S_STATUS, 32'h10);
      wr(S_VBASE, 32'h8000_1234);
      rd(S_VBASE, v); chk("R5", "vector base low bits cleared", v, 32'h8000_1000);
      wr(S_TAG, 32'h0000_005A);
      wr(S_CTX, 32'hFFFF_FFFF);
      rd(S_CTX, v); chk("R13", "context base write", v, 32'hFF80_0000);
   endtask

   task automatic t_gen_plain;
      logic r; logic [31:0] p, v;
      fire(2'd0, 5'd8, 1'b0, 1'b0, 32'h0040_0010, 1'b0, 32'hDEAD_0000, r, p);
      chk("R12", "redirect pulse", {31'b0, r}, 32'h1);
      chk("R6", "common offset", p, 32'h8000_1180);
      rd(S_EPC, v);    chk("R2", "epc no slot", v, 32'h0040_0010);
      rd(S_CAUSE, v);  chk("R4", "cause code", v, 32'h0000_0020);
      rd(S_STATUS, v); chk("R11", "exl set, kernel mode", v, 32'h0000_0002);
      rd(S_BADVA, v);  chk("R10", "badva untouched", v, 32'h0);
      @(negedge clk);
      chk("R12", "redirect drops", {31'b0, redirect}, 32'h0);
   endtask

   task automatic t_gen_dslot;
      logic r; logic [31:0] p, v;
      wr(S_STATUS, 32'h10);
      fire(2'd0, 5'd10, 1'b0, 1'b0, 32'h0040_0020, 1'b1, 32'h0, r, p);
      rd(S_EPC, v);   chk("R2", "epc delay slot", v, 32'h0040_001C);
      rd(S_CAUSE, v); chk("R2", "bd set", v, 32'h8000_0028);
   endtask

   task automatic t_exl_held;
      logic r; logic [31:0] p, v;
      fire(2'd0, 5'd12, 1'b0, 1'b0, 32'h1234_0000, 1'b0, 32'h0, r, p);
      rd(S_EPC, v);   chk("R3", "epc held", v, 32'h0040_001C);
      rd(S_CAUSE, v); chk("R3", "bd held, code updated", v, 32'h8000_0030);
      chk("R6", "nested offset", p, 32'h8000_1180);
   endtask

   task automatic t_refill;
      logic r; logic [31:0] p, v;
      wr(S_STATUS, 32'h0);
      fire(2'd0, 5'd2, 1'b1, 1'b1, 32'h0040_0040, 1'b0, 32'h7FFF_E123, r, p);
      chk("R6", "refill offset", p, 32'h8000_1000);
      rd(S_BADVA, v); chk("R9", "badva", v, 32'h7FFF_E123);
      rd(S_CTX, v);   chk("R9", "context", v, 32'hFFBF_FFF0);
      rd(S_TAG, v);   chk("R9", "tag", v, 32'h7FFF_E05A);
      fire(2'd0, 5'd2, 1'b1, 1'b1, 32'h0040_0044, 1'b0, 32'h0000_1FFF, r, p);
      chk("R6", "refill while exl set", p, 32'h8000_1180);
      rd(S_TAG, v);   chk("R9", "tag page-pair bits cleared", v, 32'h0000_005A);
      rd(S_CTX, v);   chk("R9", "context base kept", v, 32'hFF80_0000);
      fire(2'd0, 5'd8, 1'b0, 1'b0, 32'h0040_0048, 1'b0, 32'h5555_5555, r, p);
      rd(S_BADVA, v); chk("R10", "badva kept on non-fault", v, 32'h0000_1FFF);
      rd(S_TAG, v);   chk("R10", "tag kept on non-fault", v, 32'h0000_005A);
   endtask

   task automatic t_intr;
      logic r; logic [31:0] p;
      wr(S_STATUS, 32'h0);
      wr(S_CAUSE, 32'h0080_0000);
      fire(2'd0, 5'd0, 1'b0, 1'b0, 32'h0040_0100, 1'b0, 32'h0, r, p);
      chk("R6", "interrupt vector offset", p, 32'h8000_1200);
      wr(S_STATUS, 32'h0);
      wr(S_CAUSE, 32'h0);
      fire(2'd0, 5'd0, 1'b0, 1'b0, 32'h0040_0104, 1'b0, 32'h0, r, p);
      chk("R6", "interrupt without iv", p, 32'h8000_1180);
   endtask

   task automatic t_boot;
      logic r; logic [31:0] p;
      wr(S_STATUS, 32'h0040_0000);
      fire(2'd0, 5'd8, 1'b0, 1'b0, 32'h0040_0200, 1'b0, 32'h0, r, p);
      chk("R5", "boot base common", p, 32'hBFC0_0380);
      wr(S_STATUS, 32'h0040_0000);
      fire(2'd0, 5'd2, 1'b1, 1'b1, 32'h0040_0204, 1'b0, 32'h0000_2000, r, p);
      chk("R5", "boot base refill", p, 32'hBFC0_0200);
   endtask

   task automatic t_error;
      logic r; logic [31:0] p, v, e0;
      wr(S_STATUS, 32'h10);
      rd(S_EPC, e0);
      fire(2'd1, 5'd0, 1'b0, 1'b0, 32'h0040_1000, 1'b1, 32'h0, r, p);
      chk("R7", "error vector", p, 32'hBFC0_0000);
      rd(S_ERRPC, v);  chk("R7", "error return", v, 32'h0040_0FFC);
      rd(S_STATUS, v); chk("R7", "erl and bev set, kernel", v, 32'h0040_0004);
      rd(S_EPC, v);    chk("R7", "general epc untouched", v, e0);
   endtask

   task automatic t_debug;
      logic r; logic [31:0] p, v;
      wr(S_STATUS, 32'h10);
      fire(2'd2, 5'd0, 1'b0, 1'b0, 32'h0040_2000, 1'b0, 32'h0, r, p);
      chk("R8", "debug vector", p, 32'hBFC0_0480);
      rd(S_DBGPC, v);  chk("R8", "debug return", v, 32'h0040_2000);
      rd(S_STATUS, v); chk("R8", "exl unchanged, kernel mode", v, 32'h0);
      fire(2'd2, 5'd0, 1'b0, 1'b0, 32'h0040_2008, 1'b1, 32'h0, r, p);
      rd(S_DBGPC, v);  chk("R8", "debug return delay slot", v, 32'h0040_2004);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      wr(S_STATUS, 32'h0);
      @(negedge clk);
      exc_class = 2'd0; exc_code = 5'd4; exc_pc = 32'h0040_3000; exc_dslot = 1'b0;
      exc_valid = 1'b1;
      wr_en = 1'b1; wr_sel = S_STATUS; wr_data = 32'h10;
      @(negedge clk);
      exc_valid = 1'b0; wr_en = 1'b0;
      rd(S_STATUS, v); chk("R13", "write during strobe dropped", v, 32'h0000_0002);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_setup();
      t_gen_plain();
      t_gen_dslot();
      t_exl_held();
      t_refill();
      t_intr();
      t_boot();
      t_error();
      t_debug();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule